// File: doc/BRIEF.md
# Segment descriptor queue for a scatter-gather DMA engine

The block lets one card transfer span several memory segments. Software first writes a segment address register and then a command register. The command write pushes the held address and the command into a small in-order queue as one entry. A DMA engine downstream takes the oldest entry through a request/acknowledge handshake, one segment at a time.

Each command carries four things: a segment size in 64-bit words minus one, a direction bit, an endian-swap bit and an interrupt-suppress bit. Software normally leaves the interrupt enabled only on the final segment, so a whole list raises one completion pulse. A configuration register has one control bit. Setting it flushes the queue and disables it; clearing it enables the queue. The number of pending entries is always visible on an output.

Register selects on `reg_addr_i` are 0 for configuration, 1 for segment address and 2 for command; select 3 is ignored.

Top module: `seg_desc_queue`

## Requirements
- R1: After reset, `count_o` is 0, `disabled_o` is 1, and `seg_req_o`, `ovf_err_o` and `done_irq_o` are 0.
- R2: A configuration write with data bit 16 set flushes the queue (`count_o` becomes 0), sets `disabled_o` and clears `ovf_err_o`, all visible after the write edge. A configuration write with bit 16 clear enables the queue and keeps its entries.
- R3: A command write while enabled and not full appends one entry and raises `count_o` by one after the write edge.
- R4: A command write while disabled is dropped: `count_o` does not change and `ovf_err_o` is not set.
- R5: A command write while `count_o` equals DEPTH (16) is dropped and sets `ovf_err_o`. That flag stays set until a configuration write with bit 16 set.
- R6: Entries leave strictly in push order. `seg_req_o` is high exactly when the queue is enabled and not empty, and the head entry is presented on the segment outputs. An acknowledge while a request is high removes the head entry.
- R7: Command field layout: bits 19:0 hold SIZE, and `seg_words_o` is SIZE+1 (1 to 1048576 words, that is 8 MB). Bit 20 is the direction (`seg_dir_o`), bit 21 is endian swap (`seg_swap_o`) and bit 22 is interrupt suppress.
- R8: Segment addresses are 8-byte aligned. The low three bits written to the address register are discarded, and `seg_addr_o[2:0]` is always 0.
- R9: `done_irq_o` pulses high for one cycle, in the cycle after an acknowledged entry whose interrupt-suppress bit is 0. An acknowledged entry with the bit set gives no pulse.
- R10: An acknowledge while `seg_req_o` is low has no effect on `count_o` and gives no pulse.
- R11: The address register holds its value across command writes, so successive commands with no new address write reuse the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 config, 1 address, 2 command |
| reg_wdata_i | input | 64 | Register write data |
| count_o | output | 5 | Pending entry count |
| disabled_o | output | 1 | Queue flushed and disabled |
| ovf_err_o | output | 1 | Sticky dropped-push flag |
| seg_req_o | output | 1 | Head segment request |
| seg_ack_i | input | 1 | Head segment accepted |
| seg_addr_o | output | 40 | Head segment byte address |
| seg_words_o | output | 21 | Head segment length in 64-bit words |
| seg_dir_o | output | 1 | Head segment direction |
| seg_swap_o | output | 1 | Head segment endian swap |
| done_irq_o | output | 1 | Segment-done interrupt pulse |

## Verification
The queue is exercised with several stimulus patterns:
- Short in-order lists whose last entry alone has its interrupt enabled. These separate correct FIFO order and per-entry interrupt suppression from a design that is off by one or ignores the suppress bit.
- A full queue of sixteen followed by a seventeenth push. This separates the drop and the sticky overflow flag from a design that wraps its pointers.
- Pushes made while disabled, acknowledges made while empty, and re-enabling with entries held. These separate flush from enable.
- A long seeded random mix of address writes, pushes, acknowledges, flushes and enables, with misaligned addresses and extreme sizes. This checks field packing and count tracking against a model queue.

// File: rtl/seg_q_pkg.sv
package seg_q_pkg;
  typedef enum logic [1:0] {
    SEL_CFG = 2'd0,
    SEL_ADR = 2'd1,
    SEL_CMD = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned CLR_BIT = 16;
  localparam int unsigned ALIGN_BITS = 3;
endpackage

// File: rtl/seg_q_regs.sv
module seg_q_regs
  import seg_q_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned SIZE_W = 20,
  localparam int unsigned ENT_W = ADDR_W + SIZE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              push_o,
  output logic              clr_o,
  output logic              dis_o,
  output logic [ENT_W-1:0]  ent_o
);
  localparam int unsigned AW = ADDR_W - ALIGN_BITS;

  logic [AW-1:0] adr_q;
  logic          dis_q;
  logic          cfg_wr, adr_wr, cmd_wr;
  logic          unused_wdata;

  assign cfg_wr = we_i && (reg_sel_e'(sel_i) == SEL_CFG);
  assign adr_wr = we_i && (reg_sel_e'(sel_i) == SEL_ADR);
  assign cmd_wr = we_i && (reg_sel_e'(sel_i) == SEL_CMD);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adr_q <= '0;
      dis_q <= 1'b1;
    end else begin
      if (adr_wr) adr_q <= wdata_i[ADDR_W-1:ALIGN_BITS];
      if (cfg_wr) dis_q <= wdata_i[CLR_BIT];
    end
  end

  assign push_o = cmd_wr && !dis_q;
  assign clr_o  = cfg_wr && wdata_i[CLR_BIT];
  assign dis_o  = dis_q;
  // entry: command bits above the aligned address
  assign ent_o  = {wdata_i[SIZE_W+2:0], adr_q};
endmodule

// File: rtl/seg_q_store.sv
module seg_q_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned ENT_W = 60,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [ENT_W-1:0] ent_i,
  output logic [ENT_W-1:0] head_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             full, push_ok, pop_ok;
  logic [ENT_W-1:0] slot_w [DEPTH];

  function automatic logic [PTR_W-1:0] ptr_nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign push_ok = push_i && !full && !clr_i;
  assign pop_ok  = pop_i && (cnt_q != '0) && !clr_i;

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic [ENT_W-1:0] slot_q;
    always_ff @(posedge clk_i) begin
      if (push_ok && (wr_ptr_q == PTR_W'(e))) slot_q <= ent_i;
    end
    assign slot_w[e] = slot_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_nxt(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_nxt(rd_ptr_q);
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
      if (push_i && full) ovf_q <= 1'b1;
    end
  end

  assign head_o = slot_w[rd_ptr_q];
  assign cnt_o  = cnt_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/seg_q_issue.sv
module seg_q_issue
  import seg_q_pkg::*;
#(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned SIZE_W = 20,
  parameter int unsigned CNT_W = 5,
  localparam int unsigned ENT_W = ADDR_W + SIZE_W,
  localparam int unsigned AW = ADDR_W - ALIGN_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dis_i,
  input  logic              clr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [ENT_W-1:0]  head_i,
  input  logic              ack_i,
  output logic              pop_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SIZE_W:0]   words_o,
  output logic              dir_o,
  output logic              swap_o,
  output logic              irq_o
);
  logic              irq_q;
  logic              int_off;
  logic [SIZE_W-1:0] size_f;

  assign size_f  = head_i[AW +: SIZE_W];
  assign dir_o   = head_i[AW + SIZE_W];
  assign swap_o  = head_i[AW + SIZE_W + 1];
  assign int_off = head_i[AW + SIZE_W + 2];

  assign req_o   = !dis_i && (cnt_i != '0);
  assign pop_o   = req_o && ack_i && !clr_i;
  assign addr_o  = {head_i[AW-1:0], {ALIGN_BITS{1'b0}}};
  assign words_o = {1'b0, size_f} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= pop_o && !int_off;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/seg_desc_queue.sv
module seg_desc_queue #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned SIZE_W = 20,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned ENT_W = ADDR_W + SIZE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              disabled_o,
  output logic              ovf_err_o,
  output logic              seg_req_o,
  input  logic              seg_ack_i,
  output logic [ADDR_W-1:0] seg_addr_o,
  output logic [SIZE_W:0]   seg_words_o,
  output logic              seg_dir_o,
  output logic              seg_swap_o,
  output logic              done_irq_o
);
  logic             push, clr, dis, pop;
  logic [ENT_W-1:0] push_ent, head_ent;

  seg_q_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .sel_i  (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .push_o (push),
    .clr_o  (clr),
    .dis_o  (dis),
    .ent_o  (push_ent)
  );

  seg_q_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) i_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .push_i (push),
    .pop_i  (pop),
    .ent_i  (push_ent),
    .head_o (head_ent),
    .cnt_o  (count_o),
    .ovf_o  (ovf_err_o)
  );

  seg_q_issue #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) i_issue (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dis_i  (dis),
    .clr_i  (clr),
    .cnt_i  (count_o),
    .head_i (head_ent),
    .ack_i  (seg_ack_i),
    .pop_o  (pop),
    .req_o  (seg_req_o),
    .addr_o (seg_addr_o),
    .words_o(seg_words_o),
    .dir_o  (seg_dir_o),
    .swap_o (seg_swap_o),
    .irq_o  (done_irq_o)
  );

  assign disabled_o = dis;
endmodule

// File: rtl/seg_q_chk.sv
module seg_q_chk #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned CNT_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [CNT_W-1:0]  count_o,
  input logic              disabled_o,
  input logic              ovf_err_o,
  input logic              seg_req_o,
  input logic              seg_ack_i,
  input logic [ADDR_W-1:0] seg_addr_o,
  input logic              done_irq_o
);
  logic cfg_wr, flush_wr;
  assign cfg_wr   = reg_we_i && (reg_addr_i == 2'd0);
  assign flush_wr = cfg_wr && reg_wdata_i[16];

  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH)); // R5
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_err_o && !flush_wr |=> ovf_err_o); // R5
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_wr |=> (count_o == '0) && disabled_o && !ovf_err_o); // R2
  AST_REQ_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_req_o |-> (count_o != '0) && !disabled_o); // R6
  AST_ADDR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_req_o |-> (seg_addr_o[2:0] == 3'b000)); // R8
  AST_IRQ_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |-> $past(seg_req_o && seg_ack_i)); // R9
  AST_DISABLED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disabled_o && !cfg_wr |=> $stable(count_o)); // R4
  AST_IDLE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seg_req_o && !reg_we_i |=> !done_irq_o && $stable(count_o)); // R10
endmodule

bind seg_desc_queue seg_q_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .count_o    (count_o),
  .disabled_o (disabled_o),
  .ovf_err_o  (ovf_err_o),
  .seg_req_o  (seg_req_o),
  .seg_ack_i  (seg_ack_i),
  .seg_addr_o (seg_addr_o),
  .done_irq_o (done_irq_o)
);

// File: tb/test_seg_desc_queue.sv
module test_seg_desc_queue;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd3;
  logic [63:0] reg_wdata_i = '0;
  logic        seg_ack_i = 1'b0;
  logic [4:0]  count_o;
  logic        disabled_o, ovf_err_o, seg_req_o, seg_dir_o, seg_swap_o, done_irq_o;
  logic [39:0] seg_addr_o;
  logic [20:0] seg_words_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [63:0] qa[$];
  logic [63:0] qc[$];
  logic [63:0] m_adr = '0;
  bit          m_en = 0;
  bit          m_ovf = 0;

  always #4 clk_i = ~clk_i;

  seg_desc_queue i_seg_desc_queue (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .count_o(count_o), .disabled_o(disabled_o),
    .ovf_err_o(ovf_err_o), .seg_req_o(seg_req_o), .seg_ack_i(seg_ack_i),
    .seg_addr_o(seg_addr_o), .seg_words_o(seg_words_o), .seg_dir_o(seg_dir_o),
    .seg_swap_o(seg_swap_o), .done_irq_o(done_irq_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] exp_addr(logic [63:0] a);
    return {a[39:3], 3'b000};
  endfunction
  function automatic logic [20:0] exp_words(logic [63:0] c);
    return {1'b0, c[19:0]} + 21'd1;
  endfunction
  function automatic logic [63:0] mk_cmd(int unsigned size, bit dir, bit swap, bit ioff);
    return {41'd0, ioff, swap, dir, size[19:0]};
  endfunction

  task automatic wr(logic [1:0] sel, logic [63:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_addr_i = 2'd3;
  endtask

  task automatic set_adr(logic [63:0] a);
    wr(2'd1, a);
    m_adr = a;
  endtask
  task automatic push(logic [63:0] c);
    wr(2'd2, c);
    if (m_en) begin
      if (qa.size() < 16) begin qa.push_back(m_adr); qc.push_back(c); end
      else m_ovf = 1;
    end
  endtask
  task automatic cfg(bit flush);
    wr(2'd0, flush ? 64'h1_0000 : 64'h0);
    if (flush) begin qa.delete(); qc.delete(); m_ovf = 0; end
    m_en = !flush;
  endtask

  task automatic check_state(string tag);
    chk({tag, " R3 count"}, 64'(count_o), 64'(qa.size()));
    chk({tag, " R5 ovf"}, 64'(ovf_err_o), 64'(m_ovf));
    chk({tag, " R2 disabled"}, 64'(disabled_o), 64'(!m_en));
    chk({tag, " R6 req"}, 64'(seg_req_o), 64'(m_en && qa.size() != 0));
    if (m_en && qa.size() != 0) begin
      chk({tag, " R8 addr"}, 64'(seg_addr_o), 64'(exp_addr(qa[0])));
      chk({tag, " R7 words"}, 64'(seg_words_o), 64'(exp_words(qc[0])));
      chk({tag, " R7 dir"}, 64'(seg_dir_o), 64'(qc[0][20]));
      chk({tag, " R7 swap"}, 64'(seg_swap_o), 64'(qc[0][21]));
    end
  endtask

  task automatic ack(string tag);
    bit exp_irq;
    exp_irq = 0;
    @(negedge clk_i);
    seg_ack_i = 1'b1;
    if (m_en && qa.size() != 0) begin
      exp_irq = !qc[0][22];
      void'(qa.pop_front()); void'(qc.pop_front());
    end
    @(negedge clk_i);
    seg_ack_i = 1'b0;
    chk({tag, " R9 irq"}, 64'(done_irq_o), 64'(exp_irq));
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EC7_0A11);
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 count", 64'(count_o), 0);
    chk("R1 disabled", 64'(disabled_o), 1);
    chk("R1 req", 64'(seg_req_o), 0);
    chk("R1 ovf", 64'(ovf_err_o), 0);
    chk("R1 irq", 64'(done_irq_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R4 push while disabled is dropped
    set_adr(64'h12_3456_7800);
    push(mk_cmd(7, 0, 0, 0));
    check_state("R4 disabled push");
    chk("R4 count", 64'(count_o), 0);

    // R3 R8 R11 enable, reuse misaligned address for three pushes
    cfg(0);
    set_adr(64'hAB_CDEF_0125);
    push(mk_cmd(0, 1, 0, 1));
    push(mk_cmd(20'hFFFFF, 0, 1, 1));
    check_state("R11 reuse");
    push(mk_cmd(63, 1, 1, 0));
    check_state("R3 three");
    chk("R11 third addr", 64'(seg_addr_o), 64'(40'hAB_CDEF_0120));
    chk("R7 min words", 64'(seg_words_o), 1);

    // R6 R9 drain in order; interrupt only on last
    ack("R9 first");  check_state("R6 after1");
    chk("R7 max words", 64'(seg_words_o), 64'(21'h100000));
    ack("R9 second"); check_state("R6 after2");
    ack("R9 last");   check_state("R6 after3");

    // R10 ack while empty
    ack("R10 empty"); check_state("R10 empty");

    // R5 fill and overflow
    for (int i = 0; i < 16; i++) begin
      set_adr(64'(i) << 12);
      push(mk_cmd(i, i[0], i[1], 1));
    end
    check_state("R5 full");
    set_adr(64'hFF_0000);
    push(mk_cmd(3, 0, 0, 0));
    check_state("R5 overflow");
    chk("R5 ovf set", 64'(ovf_err_o), 1);
    chk("R5 count held", 64'(count_o), 16);
    ack("R6 pop after ovf"); check_state("R5 sticky");

    // R2 flush, then enable keeps contents
    cfg(1); check_state("R2 flush");
    chk("R2 flush count", 64'(count_o), 0);
    ack("R10 disabled"); check_state("R10 disabled");
    cfg(0);
    set_adr(64'h40);
    push(mk_cmd(1, 0, 0, 0));
    push(mk_cmd(2, 1, 0, 0));
    cfg(0); check_state("R2 re-enable");
    chk("R2 kept", 64'(count_o), 2);

    // random mix
    for (int k = 0; k < 600; k++) begin
      int unsigned r;
      r = $urandom % 12;
      if (r < 5) push(mk_cmd($urandom, $urandom % 2, $urandom % 2, ($urandom % 4) != 0));
      else if (r < 9) ack("R9 rand");
      else if (r == 9) set_adr({$urandom, $urandom});
      else if (r == 10 && ($urandom % 3 == 0)) cfg(m_en);
      else push(mk_cmd($urandom, 1, 1, 0));
      check_state("R6 rand");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R6 actual=hung expected=complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule